// File: doc/BRIEF.md
# PCM Serial Audio Transmitter

This block turns stereo sample pairs into a three-wire serial PCM stream: a bit clock, a channel-select (left/right) clock and a data line. The bit clock comes from the system clock through a programmable divider. Every frame has a left slot and a right slot of 32 bit-clock periods each. The timing follows the common two-channel serial audio convention. The channel clock is low for the left slot. Data and channel clock change on the falling edge of the bit clock, so a receiver can sample on the rising edge. The first data bit of a slot appears one bit period after the channel clock changes.

A run-time format setting gives the word length (16, 18, 20 or 24 bits) and the bit order (most or least significant bit first). The word is sent at the head of each slot and the rest of the slot is filled with zeros. Samples enter through a valid/ready handshake that is offered once per frame. If no sample is offered, the block sends the previous pair again. Format and divider settings are taken only at the start of a frame, so the setting never changes inside a frame.

Top module: `pcm_serial_tx`

## Requirements
- R1: Each half period of `pcm_bclk` lasts `cfg_div`+1 system clock cycles, so one full bit-clock period lasts 2*(`cfg_div`+1) cycles, using the divider value latched at frame start.
- R2: Each frame has two slots of exactly 32 bit-clock periods each. `pcm_lrclk` is low during the left slot and high during the right slot.
- R3: `pcm_lrclk` and `pcm_sdata` change only on the system clock edge where `pcm_bclk` falls.
- R4: The first data bit of a slot appears one bit-clock period after the `pcm_lrclk` transition that opens that slot.
- R5: The `cfg_prec` code selects the word length: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24.
- R6: When `cfg_lsb_first` is 0, a slot starts with sample bit W-1 and counts down to bit 0. When it is 1, a slot starts with bit 0 and counts up to bit W-1.
- R7: Slot positions W through 31 are driven as zero. Sample bits at positions W and above never reach `pcm_sdata`.
- R8: `s_ready` is a single-cycle pulse issued once per frame, at frame start. A pair presented with `s_valid` high in that cycle is sent in the new frame. Otherwise the previous pair is sent again.
- R9: Format and divider inputs are sampled only at frame start. A change made during a frame takes effect at the next left slot.
- R10: During reset `pcm_bclk`, `pcm_lrclk`, `pcm_sdata` and `s_ready` are low. The held sample pair is zero, so the first frame after reset carries zeros when no sample is supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prec | input | 2 | Word length code (16/18/20/24 bits) |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_div | input | DIV_W | Bit-clock half period minus one, in system clocks |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Frame-start pulse; a pair is taken when s_valid is high here |
| s_left | input | SAMPLE_W | Left channel sample |
| s_right | input | SAMPLE_W | Right channel sample |
| pcm_bclk | output | 1 | Serial bit clock |
| pcm_lrclk | output | 1 | Channel select clock, low = left |
| pcm_sdata | output | 1 | Serial data |

## Verification
The bench recovers every slot at the rising bit-clock edge and decodes it with the word length and bit order that applied to that frame. All eight combinations of length and order are covered, using samples whose bits above the word length are set. A design that off-by-ones the one-bit delay or the start index would return shifted or bit-reversed words. A design that leaks high bits would put ones in the padding. A design that latches the format or divider mid-frame would corrupt the frame in progress, and the directed test catches this by changing the setting just after the handshake. Separate tests cover the repeat-on-no-data rule and the all-zero first frame after reset.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    typedef enum logic [1:0] {
        PREC_16 = 2'd0,
        PREC_18 = 2'd1,
        PREC_20 = 2'd2,
        PREC_24 = 2'd3
    } prec_e;

    typedef struct packed {
        prec_e prec;
        logic  lsb_first;
    } fmt_t;

    function automatic int unsigned prec_bits(prec_e p);
        case (p)
            PREC_16: return 16;
            PREC_18: return 18;
            PREC_20: return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/pcm_bclk_div.sv
module pcm_bclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             bclk_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             bclk;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    term;

    always_comb begin
        st_d = st_q;
        term = (st_q.cnt >= div_i);
        if (term) begin
            st_d.cnt  = '0;
            st_d.bclk = ~st_q.bclk;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_o = st_q.bclk;
    assign fall_o = term & st_q.bclk;

    // R1: the divider count never runs past the active half-period limit
    assert_half_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= div_i)
        else $error("divider count beyond limit");

endmodule

// File: rtl/pcm_bit_pick.sv
module pcm_bit_pick
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int IDX_W    = 5
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  fmt_t                fmt_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic                bit_o
);
    localparam int SEL_W = $clog2(SAMPLE_W);

    int unsigned w;
    int unsigned pos;
    int unsigned sel;

    always_comb begin
        w     = prec_bits(fmt_i.prec);
        pos   = 32'(idx_i);
        sel   = 0;
        bit_o = 1'b0;
        if (pos < w) begin
            sel = fmt_i.lsb_first ? pos : (w - 1 - pos);
            if (sel < 32'(SAMPLE_W)) bit_o = sample_i[sel[SEL_W-1:0]];
        end
    end

endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int DIV_W     = 8,
    parameter int SLOT_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_i,
    input  fmt_t                cfg_fmt_i,
    input  logic [DIV_W-1:0]    cfg_div_i,
    input  logic                s_valid,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                s_ready,
    output logic [DIV_W-1:0]    div_o,
    output logic                lrclk_o,
    output logic                sdata_o
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int IDX_W      = $clog2(SLOT_BITS);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0]    pos;
        fmt_t                fmt;
        logic [DIV_W-1:0]    div;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                lrclk;
        logic                sdata;
    } seq_st_t;

    seq_st_t             st_d, st_q;
    logic [POS_W-1:0]    pos_nx;
    logic [SAMPLE_W-1:0] cur_sample;
    logic                pick_bit;

    // slot position being finished equals the current position (one-bit delay)
    assign cur_sample = st_q.pos[POS_W-1] ? st_q.right : st_q.left;

    pcm_bit_pick #(
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W)
    ) u_pick (
        .sample_i (cur_sample),
        .fmt_i    (st_q.fmt),
        .idx_i    (st_q.pos[IDX_W-1:0]),
        .bit_o    (pick_bit)
    );

    always_comb begin
        st_d    = st_q;
        pos_nx  = st_q.pos + 1'b1;
        s_ready = fall_i && (st_q.pos == LAST_POS);
        if (fall_i) begin
            st_d.pos   = pos_nx;
            st_d.lrclk = pos_nx[POS_W-1];
            st_d.sdata = pick_bit;
        end
        if (s_ready) begin
            st_d.fmt = cfg_fmt_i;
            st_d.div = cfg_div_i;
            if (s_valid) begin
                st_d.left  = s_left;
                st_d.right = s_right;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= LAST_POS;
            st_q.fmt <= '{prec: PREC_24, lsb_first: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o   = st_q.div;
    assign lrclk_o = st_q.lrclk;
    assign sdata_o = st_q.sdata;

    logic in_pad;
    assign in_pad = 32'(st_q.pos[IDX_W-1:0]) >= prec_bits(st_q.fmt.prec);

    // R7: a padding position of the slot always leaves a zero on the line
    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && in_pad) |=> !sdata_o)
        else $error("padding bit not zero");

    // R8: an accepted pair is what the frame holds afterwards
    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && s_valid) |=> (st_q.left == $past(s_left) && st_q.right == $past(s_right)))
        else $error("pair not captured");

    // R9: format and divider stay put except at frame start
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ready |=> ($stable(st_q.fmt) && $stable(st_q.div)))
        else $error("format changed mid-frame");

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int DIV_W     = 8,
    parameter int SLOT_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_prec,
    input  logic                cfg_lsb_first,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic [SAMPLE_W-1:0] s_left,
    input  logic [SAMPLE_W-1:0] s_right,
    output logic                pcm_bclk,
    output logic                pcm_lrclk,
    output logic                pcm_sdata
);
    fmt_t             cfg_fmt;
    logic [DIV_W-1:0] div_act;
    logic             fall;

    assign cfg_fmt = '{prec: prec_e'(cfg_prec), lsb_first: cfg_lsb_first};

    pcm_bclk_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_act),
        .bclk_o (pcm_bclk),
        .fall_o (fall)
    );

    pcm_frame_seq #(
        .SAMPLE_W  (SAMPLE_W),
        .DIV_W     (DIV_W),
        .SLOT_BITS (SLOT_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall),
        .cfg_fmt_i (cfg_fmt),
        .cfg_div_i (cfg_div),
        .s_valid   (s_valid),
        .s_left    (s_left),
        .s_right   (s_right),
        .s_ready   (s_ready),
        .div_o     (div_act),
        .lrclk_o   (pcm_lrclk),
        .sdata_o   (pcm_sdata)
    );

    // R3: channel clock moves only together with a falling bit clock
    assert_lr_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_lrclk != $past(pcm_lrclk)) |-> $fell(pcm_bclk))
        else $error("lrclk moved off a falling edge");

    // R3: data moves only together with a falling bit clock
    assert_sd_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_sdata != $past(pcm_sdata)) |-> $fell(pcm_bclk))
        else $error("data moved off a falling edge");

    // R8: ready never lasts more than one cycle
    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready)
        else $error("ready held too long");

endmodule

// File: tb/sim_pcm_serial_tx.sv
module sim_pcm_serial_tx;
    localparam int SW = 24;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_prec = 2'd3;
    logic          cfg_lsb_first = 1'b0;
    logic [DW-1:0] cfg_div = '0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [SW-1:0] s_left = '0;
    logic [SW-1:0] s_right = '0;
    logic          pcm_bclk, pcm_lrclk, pcm_sdata;

    always #10 clk = ~clk;   // 50 MHz

    pcm_serial_tx #(.SAMPLE_W(SW), .DIV_W(DW), .SLOT_BITS(32)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_prec(cfg_prec), .cfg_lsb_first(cfg_lsb_first),
        .cfg_div(cfg_div), .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left),
        .s_right(s_right), .pcm_bclk(pcm_bclk), .pcm_lrclk(pcm_lrclk), .pcm_sdata(pcm_sdata));

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // fields: prec[58:57] lsb[56] div[55:48] left[47:24] right[23:0]
    localparam logic [58:0] VEC [8] = '{
        {2'd0, 1'b0, 8'd0, 24'hA5C3F1, 24'h0F1E2D},
        {2'd0, 1'b1, 8'd1, 24'hFF8001, 24'h7E0A53},
        {2'd1, 1'b0, 8'd2, 24'hC2B4E7, 24'h9D1F06},
        {2'd1, 1'b1, 8'd0, 24'hF3A5A5, 24'hE0C381},
        {2'd2, 1'b0, 8'd3, 24'hB8765D, 24'h4C3B2A},
        {2'd2, 1'b1, 8'd1, 24'hFFF00F, 24'hAA5500},
        {2'd3, 1'b0, 8'd0, 24'h800001, 24'h123456},
        {2'd3, 1'b1, 8'd2, 24'h7FFFFE, 24'hC0FFEE}
    };

    // deserializer state, sampled at system negedges
    logic [31:0] cur = '0, raw_l = '0, raw_r = '0;
    int   bcnt = 0, slot_len = 0, rdone = 0, per = 0, per_cnt = 0;
    logic prev_lr = 1'b1, prev_bclk = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_bclk = 1'b0;
        end else begin
            per_cnt++;
            if (pcm_bclk && !prev_bclk) begin
                per = per_cnt;
                per_cnt = 0;
                if (pcm_lrclk != prev_lr) begin
                    if (bcnt < 32) cur[bcnt] = pcm_sdata;
                    slot_len = bcnt + 1;
                    if (prev_lr) begin raw_r = cur; rdone++; end
                    else raw_l = cur;
                    cur = '0;
                    bcnt = 0;
                    prev_lr = pcm_lrclk;
                end else begin
                    if (bcnt < 32) cur[bcnt] = pcm_sdata;
                    bcnt++;
                end
            end
            prev_bclk = pcm_bclk;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int wof(logic [1:0] p);
        case (p) 2'd0: return 16; 2'd1: return 18; 2'd2: return 20; default: return 24; endcase
    endfunction

    function automatic logic [31:0] dec(logic [31:0] raw, int w, logic lsb);
        logic [31:0] v = '0;
        for (int i = 0; i < w; i++) begin
            if (lsb) v[i] = raw[i];
            else     v[w-1-i] = raw[i];
        end
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic handshake(logic [1:0] p, logic lsb, logic [DW-1:0] d,
                             logic [SW-1:0] l, logic [SW-1:0] r, output int r0);
        @(negedge clk);
        cfg_prec = p; cfg_lsb_first = lsb; cfg_div = d;
        s_left = l; s_right = r; s_valid = 1'b1;
        do @(negedge clk); while (!s_ready);
        @(negedge clk);
        s_valid = 1'b0;
        r0 = rdone;
    endtask

    task automatic check_frame(logic [1:0] p, logic lsb, logic [SW-1:0] l, logic [SW-1:0] r, string tag);
        int w = wof(p);
        logic [31:0] mask = (32'd1 << w) - 1;
        logic [31:0] el = {8'd0, l} & mask;
        logic [31:0] er = {8'd0, r} & mask;
        chk(dec(raw_l, w, lsb) == el, {tag, " R5 R6 left"}, dec(raw_l, w, lsb), el);
        chk(dec(raw_r, w, lsb) == er, {tag, " R5 R6 right"}, dec(raw_r, w, lsb), er);
        chk((raw_l >> w) == 0 && (raw_r >> w) == 0, {tag, " R7 padding"}, raw_l | raw_r, mask);
    endtask

    initial begin
        int r0;
        // R10: reset levels
        repeat (4) @(negedge clk);
        chk(!pcm_bclk && !pcm_lrclk && !pcm_sdata && !s_ready, "R10 reset outputs",
            {28'd0, pcm_bclk, pcm_lrclk, pcm_sdata, s_ready}, 32'd0);
        rst_n = 1'b1;
        // R10: first frame after reset with no sample is all zero
        while (rdone < 2) @(negedge clk);
        chk(raw_l == 0 && raw_r == 0, "R10 zero first frame", raw_l | raw_r, 32'd0);

        // table of all precision and order combinations
        for (int i = 0; i < 8; i++) begin
            logic [58:0] v = VEC[i];
            handshake(v[58:57], v[56], v[55:48], v[47:24], v[23:0], r0);
            while (rdone < r0 + 2) @(negedge clk);
            check_frame(v[58:57], v[56], v[47:24], v[23:0], "vec");
            chk(slot_len == 32, "R2 slot length", slot_len, 32);
            chk(per == 2 * (int'(v[55:48]) + 1), "R1 bit period", per, 2 * (int'(v[55:48]) + 1));
            if (!v[56]) begin
                // R4: first bit after the channel change is the top bit of the word
                chk(raw_l[0] == v[24 + wof(v[58:57]) - 1], "R4 first bit", raw_l[0],
                    v[24 + wof(v[58:57]) - 1]);
            end
        end

        // R9: change format right after the handshake; the running frame keeps the old one
        handshake(2'd3, 1'b0, 8'd1, 24'hF0A50F, 24'h3C96E1, r0);
        cfg_prec = 2'd0; cfg_lsb_first = 1'b1; cfg_div = 8'd2;
        while (rdone < r0 + 2) @(negedge clk);
        check_frame(2'd3, 1'b0, 24'hF0A50F, 24'h3C96E1, "R9 hold");
        // R8 + R9: next frame repeats the pair, now with the new format
        while (rdone < r0 + 3) @(negedge clk);
        check_frame(2'd0, 1'b1, 24'hF0A50F, 24'h3C96E1, "R8 repeat R9 apply");
        chk(per == 6, "R9 divider applied", per, 6);

        // R8: ready pulse lasts a single cycle
        do @(negedge clk); while (!s_ready);
        @(negedge clk);
        chk(!s_ready, "R8 ready pulse", s_ready, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule